// File: doc/BRIEF.md
# DMA Channel Register Alias Controller

This block is the programming front end and sequencing core of one DMA channel. A simple register bus reaches a window of sixteen 32-bit words. Four channel registers live behind that window: a read pointer, a write pointer, a transfer length and a control word. The window shows these four registers in four different orders. The last word of every group of four is a trigger slot. Software can therefore update up to three registers and then start the channel with a single final write, and it picks the group whose trigger slot holds the register it wants to set last.

The transfer length has two copies. One is a stored reload value, which every write to the length register updates. The other is a live counter, which is loaded when the channel starts. While the channel runs, the memory side reports each finished read and each finished write with a one-cycle pulse. A finished read moves the read pointer forward. A finished write moves the write pointer forward and takes one from the live counter. The channel goes idle when the counter reaches zero. Each pointer moves by 1, 2 or 4 bytes, set by the transfer size in the control word, or stays where it is when its increment bit is clear.

Top module: `dma_chan_alias_ctl`

## Requirements
- R1: After reset, all four registers read as zero and `busy` is low.
- R2: The register at word index w (byte offset 4*w) is set by group g = w/4 and slot s = w%4. Group 0 holds read pointer, write pointer, length, control. Group 1 holds control, read pointer, write pointer, length. Group 2 holds control, length, read pointer, write pointer. Group 3 holds control, write pointer, length, read pointer. Every alias of a register reads and writes the same storage.
- R3: A write to slot 3 of any group (words 3, 7, 11, 15) updates the register there. It also starts the channel when all three of these hold: the written value is nonzero, the enable bit is set once the write is done, and the run length is nonzero. `busy` is high from the next cycle.
- R4: Writing zero to a trigger slot that holds a pointer or the control word updates that register and does not start the channel.
- R5: Every write to the length register stores the reload value. Each start that comes from a non-length trigger copies the reload value into the live counter, so repeated starts run the same length.
- R6: When the length register is itself the trigger (word 7), the written value becomes the run length at once and is also stored as the reload value. Writing zero there stores zero and starts nothing.
- R7: Reading the length returns the live remaining count while `busy` is high, and the reload value while it is low.
- R8: Each `wr_done` pulse while busy takes one from the live count. `busy` falls in the cycle after the pulse that brings the count to zero.
- R9: Each `rd_done` while busy moves the read pointer forward, and each `wr_done` while busy moves the write pointer forward. The step is 1 byte for size code 0, 2 bytes for code 1, and 4 bytes for codes 2 and 3.
- R10: A pointer whose increment bit is clear keeps its value across completions.
- R11: A trigger that arrives while busy restarts the run with the new length from the next cycle, and `busy` stays high.
- R12: The control word holds enable in bit 0, size in bits 2:1, read-increment in bit 3 and write-increment in bit 4. Bit 31 reads `busy` and cannot be written. All other bits read zero. A control write with enable clear stops an active run, and a trigger with enable clear starts nothing.
- R13: `rd_done` and `wr_done` are ignored while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read enable; read data is zero when low |
| bus_word | input | 4 | Word index within the window (byte offset / 4) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from `bus_word` |
| rd_done | input | 1 | Pulse: one read transfer completed |
| wr_done | input | 1 | Pulse: one write transfer completed |
| rd_addr | output | DATA_W | Next read address |
| wr_addr | output | DATA_W | Next write address |
| busy | output | 1 | Channel active |

## Verification
The bench writes a register through one alias and reads it through the others. A decoder with a wrong group order would return the wrong register for these reads. Starts come from each of the four trigger slots, and the cases include a zero value, a length trigger that differs from the stored reload, and a restart partway through a run. A design that always copied the reload value, or that started on zero, would give a wrong live count or raise `busy` by mistake. The bench also switches the size and increment bits while a run is active, so a wrong step table or a pointer that ignores its increment bit shows up as a wrong pointer value. It sends completion pulses while idle, so a design that counted them would move a pointer it must leave alone.

// File: rtl/dma_alias_pkg.sv
// Shared types for the DMA channel alias controller.
// Assumes a 16-word window made of four groups of four slots.
package dma_alias_pkg;

    localparam int WIN_IDX_W = 4;
    localparam int CTL_BITS  = 5;

    typedef enum logic [1:0] {
        REG_RPTR = 2'd0,
        REG_WPTR = 2'd1,
        REG_LEN  = 2'd2,
        REG_CTL  = 2'd3
    } dma_reg_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } dma_size_e;

    // Stored control bits: en is bit 0, size bits 2:1, rinc bit 3, winc bit 4
    typedef struct packed {
        logic      winc;
        logic      rinc;
        dma_size_e size;
        logic      en;
    } dma_ctl_t;

    // Map a group and a slot to the register it aliases
    function automatic dma_reg_e alias_lookup(input logic [1:0] grp, input logic [1:0] slot);
        dma_reg_e r;
        unique case (grp)
            2'd0: r = (slot == 2'd0) ? REG_RPTR : (slot == 2'd1) ? REG_WPTR :
                      (slot == 2'd2) ? REG_LEN  : REG_CTL;
            2'd1: r = (slot == 2'd0) ? REG_CTL  : (slot == 2'd1) ? REG_RPTR :
                      (slot == 2'd2) ? REG_WPTR : REG_LEN;
            2'd2: r = (slot == 2'd0) ? REG_CTL  : (slot == 2'd1) ? REG_LEN  :
                      (slot == 2'd2) ? REG_RPTR : REG_WPTR;
            default: r = (slot == 2'd0) ? REG_CTL : (slot == 2'd1) ? REG_WPTR :
                         (slot == 2'd2) ? REG_LEN : REG_RPTR;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/dma_alias_decode.sv
// Window decoder: turns a word index into a register id and a trigger flag.
// Assumes the upper two index bits pick the group and the lower two the slot.
module dma_alias_decode
    import dma_alias_pkg::*;
(
    input  logic [WIN_IDX_W-1:0] word,
    output dma_reg_e             reg_id,
    output logic                 is_trig
);
    localparam logic [1:0] TRIG_SLOT = 2'd3;

    // Resolve the alias and flag the last slot of the group
    always_comb begin
        reg_id  = alias_lookup(word[3:2], word[1:0]);
        is_trig = (word[1:0] == TRIG_SLOT);
    end
endmodule

// File: rtl/dma_addr_step.sv
// Address step generator: gives the byte stride for one transfer.
// Assumes that the reserved size code behaves like a word transfer.
module dma_addr_step
    import dma_alias_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  dma_size_e         size,
    input  logic              inc,
    output logic [DATA_W-1:0] step
);
    // Pick the stride from the size, or zero when incrementing is off
    always_comb begin
        if (!inc) begin
            step = '0;
        end else begin
            unique case (size)
                SZ_BYTE: step = DATA_W'(1);
                SZ_HALF: step = DATA_W'(2);
                default: step = DATA_W'(4);
            endcase
        end
    end
endmodule

// File: rtl/dma_chan_core.sv
// Channel state and sequencing: holds the pointers, reload and live count,
// and control, and runs the start, count-down, restart and abort logic.
// Assumes at most one register write per cycle. A bus write to a pointer
// takes priority over that pointer's own advance in the same cycle.
module dma_chan_core
    import dma_alias_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  dma_reg_e          wr_id,
    input  logic              is_trig,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd_done,
    input  logic              wr_done,
    output logic [DATA_W-1:0] rptr,
    output logic [DATA_W-1:0] wptr,
    output logic [DATA_W-1:0] reload,
    output logic [DATA_W-1:0] live,
    output dma_ctl_t          ctl,
    output logic              busy,
    output logic              start,
    output logic              abort,
    output logic [3:0]        strobe
);
    localparam int NREG = 4;

    logic [DATA_W-1:0] rptr_q, wptr_q, reload_q, live_q;
    logic [DATA_W-1:0] rstep, wstep, start_len;
    logic [NREG-1:0]   strobe_w;
    dma_ctl_t          ctl_q;
    logic              busy_q, en_after, start_w, abort_w, last_wr;

    dma_addr_step #(.DATA_W(DATA_W)) rstep_i (.size(ctl_q.size), .inc(ctl_q.rinc), .step(rstep));
    dma_addr_step #(.DATA_W(DATA_W)) wstep_i (.size(ctl_q.size), .inc(ctl_q.winc), .step(wstep));

    // One-hot write strobe per register
    always_comb strobe_w = wr_en ? (NREG'(1) << wr_id) : '0;

    // Decide start, abort and final completion for this cycle
    always_comb begin
        en_after  = strobe_w[REG_CTL] ? wdata[0] : ctl_q.en;
        start_len = (wr_id == REG_LEN) ? wdata : reload_q;
        start_w   = wr_en && is_trig && (wdata != '0) && en_after && (start_len != '0);
        abort_w   = strobe_w[REG_CTL] && !wdata[0] && busy_q;
        last_wr   = busy_q && wr_done && (live_q == DATA_W'(1));
    end

    // Control word and reload value follow bus writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            reload_q <= '0;
        end else begin
            if (strobe_w[REG_CTL]) ctl_q    <= dma_ctl_t'(wdata[CTL_BITS-1:0]);
            if (strobe_w[REG_LEN]) reload_q <= wdata;
        end
    end

    // Read pointer: bus write, else advance on read completion
    always_ff @(posedge clk) begin
        if (!rst_n)                  rptr_q <= '0;
        else if (strobe_w[REG_RPTR]) rptr_q <= wdata;
        else if (busy_q && rd_done)  rptr_q <= rptr_q + rstep;
    end

    // Write pointer: bus write, else advance on write completion
    always_ff @(posedge clk) begin
        if (!rst_n)                  wptr_q <= '0;
        else if (strobe_w[REG_WPTR]) wptr_q <= wdata;
        else if (busy_q && wr_done)  wptr_q <= wptr_q + wstep;
    end

    // Live counter and busy flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q <= '0;
            busy_q <= 1'b0;
        end else if (start_w) begin
            live_q <= start_len;
            busy_q <= 1'b1;
        end else if (abort_w) begin
            live_q <= '0;
            busy_q <= 1'b0;
        end else if (busy_q && wr_done) begin
            live_q <= live_q - DATA_W'(1);
            if (last_wr) busy_q <= 1'b0;
        end
    end

    assign rptr   = rptr_q;
    assign wptr   = wptr_q;
    assign reload = reload_q;
    assign live   = live_q;
    assign ctl    = ctl_q;
    assign busy   = busy_q;
    assign start  = start_w;
    assign abort  = abort_w;
    assign strobe = strobe_w;
endmodule

// File: rtl/dma_chan_alias_ctl.sv
// Top of one DMA channel: aliased register window, read-back mux and
// sequencing core. Assumes read data is sampled in the same cycle as
// bus_rd_en and that rd_done and wr_done are single-cycle pulses.
module dma_chan_alias_ctl
    import dma_alias_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr_en,
    input  logic                 bus_rd_en,
    input  logic [WIN_IDX_W-1:0] bus_word,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic                 rd_done,
    input  logic                 wr_done,
    output logic [DATA_W-1:0]    rd_addr,
    output logic [DATA_W-1:0]    wr_addr,
    output logic                 busy
);
    dma_reg_e          reg_id;
    logic              is_trig;
    logic [DATA_W-1:0] rptr_w, wptr_w, reload_w, live_w, ctl_word;
    dma_ctl_t          ctl_w;
    logic              busy_w, start_w, abort_w;
    logic [3:0]        strobe_w;

    dma_alias_decode dec_i (.word(bus_word), .reg_id(reg_id), .is_trig(is_trig));

    dma_chan_core #(.DATA_W(DATA_W)) core_i (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr_en), .wr_id(reg_id), .is_trig(is_trig),
        .wdata(bus_wdata), .rd_done(rd_done), .wr_done(wr_done),
        .rptr(rptr_w), .wptr(wptr_w), .reload(reload_w), .live(live_w), .ctl(ctl_w),
        .busy(busy_w), .start(start_w), .abort(abort_w), .strobe(strobe_w)
    );

    // Build the visible control word with the busy status on top
    always_comb begin
        ctl_word               = '0;
        ctl_word[CTL_BITS-1:0] = ctl_w;
        ctl_word[DATA_W-1]     = busy_w;
    end

    // Read-back mux; the length shows the live count while running
    always_comb begin
        bus_rdata = '0;
        if (bus_rd_en) begin
            unique case (reg_id)
                REG_RPTR: bus_rdata = rptr_w;
                REG_WPTR: bus_rdata = wptr_w;
                REG_LEN:  bus_rdata = busy_w ? live_w : reload_w;
                default:  bus_rdata = ctl_word;
            endcase
        end
    end

    assign rd_addr = rptr_w;
    assign wr_addr = wptr_w;
    assign busy    = busy_w;
endmodule

// File: rtl/dma_chan_alias_ctl_chk.sv
// Property checker for the DMA channel alias controller, bound into the top.
// Assumes it sees the core's internal strobes through the bind.
module dma_chan_alias_ctl_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic [DATA_W-1:0] live,
    input logic [DATA_W-1:0] rptr,
    input logic              rd_done,
    input logic              wr_done,
    input logic              start,
    input logic              abort,
    input logic [3:0]        strobe
);
    a_r2_onehot_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(strobe));

    a_r3_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);

    a_r11_start_loads_len: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (live != '0));

    a_r8_busy_has_count: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (live != '0));

    a_r8_last_write_halts: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_done && (live == DATA_W'(1)) && !start) |=> !busy);

    a_r12_abort_idles: assert property (@(posedge clk) disable iff (!rst_n)
        (abort && !start) |=> !busy);

    a_r13_rptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!(busy && rd_done) && !strobe[0]) |=> $stable(rptr));
endmodule

bind dma_chan_alias_ctl dma_chan_alias_ctl_chk #(.DATA_W(DATA_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .busy(busy_w), .live(live_w), .rptr(rptr_w),
    .rd_done(rd_done), .wr_done(wr_done), .start(start_w), .abort(abort_w),
    .strobe(strobe_w)
);

// File: tb/dma_chan_alias_ctl_tb_top.sv
// Scoreboard bench: the driver tasks queue expected values and a monitor compares them.
module dma_chan_alias_ctl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;

    typedef struct {
        int          kind;   // 0 rdata, 1 rd_addr, 2 wr_addr, 3 busy
        logic [31:0] exp;
        string       tag;
    } sb_item_t;

    logic clk = 0, rst_n = 0;
    logic bus_wr_en = 0, bus_rd_en = 0, rd_done = 0, wr_done = 0;
    logic [3:0] bus_word = '0;
    logic [DW-1:0] bus_wdata = '0, bus_rdata, rd_addr, wr_addr;
    logic busy;

    sb_item_t sb_q[$];
    event sb_ev;
    int checks = 0, fails = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_chan_alias_ctl #(.DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
        .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rd_done(rd_done), .wr_done(wr_done), .rd_addr(rd_addr), .wr_addr(wr_addr),
        .busy(busy)
    );

    // Monitor: pop expectations and compare against the design's outputs
    initial forever begin
        @(sb_ev);
        while (sb_q.size() > 0) begin
            sb_item_t it;
            logic [31:0] act;
            it = sb_q.pop_front();
            case (it.kind)
                0: act = bus_rdata;
                1: act = rd_addr;
                2: act = wr_addr;
                default: act = {31'd0, busy};
            endcase
            checks++;
            if (act !== it.exp) begin
                fails++;
                $display("FAIL %s: actual 0x%08h expected 0x%08h", it.tag, act, it.exp);
            end
        end
    end

    task automatic push_exp(int kind, logic [31:0] exp, string tag);
        sb_item_t it;
        it.kind = kind; it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
        ->sb_ev;
        #1;
    endtask

    task automatic bus_write(int w, logic [31:0] d);
        @(negedge clk);
        bus_wr_en = 1; bus_word = 4'(w); bus_wdata = d;
        @(negedge clk);
        bus_wr_en = 0; bus_wdata = '0;
    endtask

    task automatic read_chk(int w, logic [31:0] exp, string tag);
        @(negedge clk);
        bus_rd_en = 1; bus_word = 4'(w);
        #1;
        push_exp(0, exp, tag);
        bus_rd_en = 0;
    endtask

    task automatic out_chk(int kind, logic [31:0] exp, string tag);
        @(negedge clk);
        #1;
        push_exp(kind, exp, tag);
    endtask

    task automatic pulse_rd();
        @(negedge clk); rd_done = 1;
        @(negedge clk); rd_done = 0;
    endtask

    task automatic pulse_wr();
        @(negedge clk); wr_done = 1;
        @(negedge clk); wr_done = 0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    // Driver
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        read_chk(0, 32'h0, "R1 rptr");
        read_chk(1, 32'h0, "R1 wptr");
        read_chk(2, 32'h0, "R1 len");
        read_chk(3, 32'h0, "R1 ctl");
        out_chk(3, 32'h0, "R1 busy");

        // R2 alias decode across groups
        bus_write(5, 32'h1000);
        bus_write(13, 32'h2000);
        bus_write(9, 32'd3);
        read_chk(0, 32'h1000, "R2 rptr g0");
        read_chk(10, 32'h1000, "R2 rptr g2");
        read_chk(1, 32'h2000, "R2 wptr g0");
        read_chk(6, 32'h2000, "R2 wptr g1");
        read_chk(14, 32'd3, "R2 len g3");
        read_chk(2, 32'd3, "R2 len g0");
        bus_write(8, 32'h1D);
        read_chk(12, 32'h1D, "R12 ctl readback");
        out_chk(3, 32'h0, "R2 non-trigger ctl no start");

        // R4 zero to pointer trigger slot
        bus_write(11, 32'h0);
        read_chk(1, 32'h0, "R4 wptr cleared");
        out_chk(3, 32'h0, "R4 no start");
        bus_write(1, 32'h2000);

        // R3 start from read-pointer trigger
        bus_write(15, 32'h1000);
        out_chk(3, 32'h1, "R3 busy");
        read_chk(2, 32'd3, "R7 live count");
        read_chk(4, 32'h8000001D, "R12 busy bit");

        // R9 word steps, R8 count down
        pulse_rd();
        out_chk(1, 32'h1004, "R9 rptr word step");
        pulse_wr();
        out_chk(2, 32'h2004, "R9 wptr word step");
        read_chk(2, 32'd2, "R8 live after one");
        pulse_rd(); pulse_wr(); pulse_rd(); pulse_wr();
        out_chk(1, 32'h100C, "R9 rptr end");
        out_chk(2, 32'h200C, "R9 wptr end");
        out_chk(3, 32'h0, "R8 halt at zero");
        read_chk(2, 32'd3, "R7 idle shows reload");

        // R13 pulses ignored when idle
        pulse_rd(); pulse_wr();
        out_chk(1, 32'h100C, "R13 rptr idle");
        out_chk(2, 32'h200C, "R13 wptr idle");

        // R5 control trigger reuses reload
        bus_write(3, 32'h1D);
        out_chk(3, 32'h1, "R5 busy");
        read_chk(2, 32'd3, "R5 reload copied");
        pulse_wr(); pulse_wr(); pulse_wr();
        out_chk(3, 32'h0, "R5 same length");

        // R6 length trigger
        bus_write(7, 32'd2);
        out_chk(3, 32'h1, "R6 busy");
        read_chk(2, 32'd2, "R6 live is written value");
        pulse_wr(); pulse_wr();
        out_chk(3, 32'h0, "R6 halt after two");
        read_chk(14, 32'd2, "R6 reload stored");

        // R11 restart while busy
        bus_write(7, 32'd5);
        pulse_wr();
        read_chk(2, 32'd4, "R11 live before restart");
        bus_write(7, 32'd2);
        out_chk(3, 32'h1, "R11 still busy");
        read_chk(2, 32'd2, "R11 new length");

        // R12 abort by clearing enable
        bus_write(4, 32'h1C);
        out_chk(3, 32'h0, "R12 abort");
        read_chk(3, 32'h1C, "R12 ctl no busy");

        // R6 zero length trigger
        bus_write(7, 32'h0);
        out_chk(3, 32'h0, "R6 zero no start");
        read_chk(2, 32'h0, "R6 zero reload");

        // R10 fixed pointer, R9 halfword and byte steps
        bus_write(9, 32'd4);
        bus_write(8, 32'h13);
        bus_write(10, 32'h500);
        bus_write(13, 32'h600);
        bus_write(11, 32'h600);
        out_chk(3, 32'h1, "R3 start from wptr trigger");
        pulse_rd();
        out_chk(1, 32'h500, "R10 rptr fixed");
        pulse_wr();
        out_chk(2, 32'h602, "R9 halfword step");
        bus_write(12, 32'h19);
        out_chk(3, 32'h1, "R12 enable kept");
        pulse_rd();
        out_chk(1, 32'h501, "R9 byte step rptr");
        pulse_wr();
        out_chk(2, 32'h603, "R9 byte step wptr");
        read_chk(14, 32'd2, "R7 live mid run");

        // R12 trigger with enable clear
        bus_write(12, 32'h18);
        out_chk(3, 32'h0, "R12 abort second");
        bus_write(15, 32'h700);
        out_chk(3, 32'h0, "R12 disabled trigger");
        out_chk(1, 32'h700, "R12 rptr written");

        repeat (2) @(negedge clk);
        done = 1;
        summary();
        $finish;
    end
endmodule